// File: doc/BRIEF.md
# Dual Interval Timer with Merged Interrupt

This block holds two identical down-counting interval timers behind one 4 KB register window. Each timer owns a 32-byte bank of word registers. The lower bank starts at offset 0x00 and the upper bank starts at offset 0x20. The block decodes the byte address and steers a write to the timer that owns it. It also returns that timer's word on `rdata_o`, which is combinational in the same cycle. Offsets from 0x40 up to the end of the window belong to no timer.

Both timers advance on one shared `tick_i` strobe, which carries the reference rate. Each timer can divide that rate before counting. A timer can run in one of three modes: free-running with a fixed wrap value, periodic reload from a programmed limit, or one-shot. Each timer keeps its own pending interrupt flag and its own enable for that flag. The two masked flags are ORed onto the single `irq_o` line.

Bank layout, as word offsets within a bank:
- 0x00: limit. Writing it also reloads the count.
- 0x04: current count. Read only.
- 0x08: control.
- 0x0C: interrupt clear. Write only.
- 0x10: raw pending flag.
- 0x14: masked pending flag.
- 0x18: background limit. Writing it sets the limit without reloading the count.

Control bits:
- bit 0: run.
- bit 1: periodic.
- bit 2: one-shot. It takes precedence over periodic.
- bit 3: 32-bit width. When clear, the timer is 16 bits wide.
- bits 5:4: prescale. 0 divides by 1, 1 divides by 16, 2 divides by 256.
- bit 6: interrupt enable.

Top module: `dual_timer`

## Requirements
- R1: Accesses at byte offsets 0x00 to 0x1F reach timer 0 with the offset unchanged.
- R2: Accesses at offsets 0x20 to 0x3F reach timer 1 with 0x20 subtracted, so offset 0x20 is that timer's limit and 0x24 is its count.
- R3: Offsets 0x40 and above within the window read as zero, and writes to them change neither timer.
- R4: Address bits [1:0] are ignored. For example, 0x03 reads the same word as 0x00, and a write to 0x22 lands on offset 0x20.
- R5: `irq_o` is high whenever either timer has a pending flag with its enable set. Clearing one timer's flag leaves the other flag, and the line, asserted.
- R6: After reset, control reads 0x40 (interrupt enable only), and limit, count and raw flag read 0 in both timers. `irq_o` is low.
- R7: In periodic mode with limit N, the count steps down once per scaled tick. On the scaled tick where the count is 1, the raw flag sets and the count reloads to N.
- R8: In one-shot mode, on the scaled tick where the count is 1, the raw flag sets, the count becomes 0 and the run bit (bit 0) clears, so further ticks leave the count at 0.
- R9: In free-running mode (bits 1 and 2 both 0) the reload value is 0xFFFF at 16-bit width and 0xFFFFFFFF at 32-bit width. At 16-bit width a periodic limit is truncated to its low 16 bits.
- R10: Prescale code 1 produces one count step per 16 ticks, and code 2 one step per 256 ticks. Writing control restarts the prescaler.
- R11: A write to offset 0x18 updates the limit and leaves the count untouched. Writes to the count register at 0x04 are ignored. A control write with bit 0 set reloads the count.
- R12: A write to 0x0C clears the raw flag. The masked flag at 0x14 equals raw AND bit 6, and a timer with bit 6 clear never drives `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Shared count-rate strobe, one cycle wide |
| sel_i | input | 1 | Register access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Merged interrupt level |

## Verification
The address decode is tried with aligned offsets, with unaligned offsets, and with offsets above both banks. Together these separate a correct rebase from aliasing, and show whether the low address bits are dropped. The counting path is driven in periodic, one-shot and free-running modes, at both widths, and under each prescale code. Tick counts are chosen to stop one tick short of an expiry and then on the expiry itself, which exposes off-by-one reload and divider faults. The interrupt tests keep both timers pending at once and then clear them one at a time, with the enable on and off. This separates a correct OR of per-timer state from a shared or unmasked flag.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  localparam int unsigned CTRL_W     = 7;
  localparam int unsigned CB_RUN     = 0;
  localparam int unsigned CB_PER     = 1;
  localparam int unsigned CB_ONE     = 2;
  localparam int unsigned CB_WIDE    = 3;
  localparam int unsigned CB_DIV     = 4;
  localparam int unsigned CB_IE      = 6;
  localparam logic [CTRL_W-1:0] CTRL_RST = 7'h40;

  localparam int unsigned BANK_SHIFT = 5;
  localparam int unsigned BANK_BYTES = 1 << BANK_SHIFT;
  localparam int unsigned IDX_W      = BANK_SHIFT - 2;

  typedef enum logic [IDX_W-1:0] {
    RI_LIMIT  = 3'd0,
    RI_COUNT  = 3'd1,
    RI_CTRL   = 3'd2,
    RI_ICLR   = 3'd3,
    RI_RAW    = 3'd4,
    RI_MASKED = 3'd5,
    RI_BGLIM  = 3'd6,
    RI_SPARE  = 3'd7
  } reg_idx_e;

endpackage

// File: rtl/dtm_rst_sync.sv
module dtm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/dtm_decode.sv
module dtm_decode
  import dtm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned N_TIMERS = 2
) (
  input  logic                sel_i,
  input  logic [ADDR_W-3:0]   word_addr_i,
  output logic [N_TIMERS-1:0] hit_o,
  output reg_idx_e            idx_o
);
  localparam int unsigned BANK_W = ADDR_W - BANK_SHIFT;

  logic [BANK_W-1:0] bank;
  assign bank  = word_addr_i[ADDR_W-3:BANK_SHIFT-2];
  assign idx_o = reg_idx_e'(word_addr_i[IDX_W-1:0]);

  for (genvar gi = 0; gi < N_TIMERS; gi++) begin : g_hit
    assign hit_o[gi] = sel_i && (bank == BANK_W'(gi));
  end
endmodule

// File: rtl/dtm_prescaler.sv
module dtm_prescaler #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned MID_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [1:0] div_i,
  output logic       stb_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic             pre_en;
  logic             wrap;

  always_comb begin
    unique case (div_i)
      2'd1:    wrap = &pre_q[MID_W-1:0];
      2'd2:    wrap = &pre_q;
      default: wrap = 1'b1;
    endcase
  end

  assign stb_o = run_i && tick_i && wrap;

  always_comb begin
    pre_en = clr_i || (run_i && tick_i);
    pre_d  = clr_i ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (pre_en) begin
      pre_q <= pre_d;
    end
  end
endmodule

// File: rtl/dtm_timer.sv
module dtm_timer
  import dtm_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned PRE_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  reg_idx_e          idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              raw_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] limit_q, limit_d;
  logic [DATA_W-1:0] count_q, count_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              raw_q, raw_d;
  logic              wr_hit, ctrl_wr, stb, expire;

  function automatic logic [DATA_W-1:0] reload_of(input logic [CTRL_W-1:0] c,
                                                  input logic [DATA_W-1:0] lim);
    logic [DATA_W-1:0] msk;
    msk = c[CB_WIDE] ? '1 : DATA_W'({NARROW_W{1'b1}});
    if (!c[CB_PER] && !c[CB_ONE]) begin
      return msk;
    end
    return lim & msk;
  endfunction

  assign wr_hit  = sel_i && wr_i;
  assign ctrl_wr = wr_hit && (idx_i == RI_CTRL);

  dtm_prescaler #(
    .PRE_W(PRE_W),
    .MID_W(4)
  ) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ctrl_wr),
    .run_i (ctrl_q[CB_RUN]),
    .tick_i(tick_i),
    .div_i (ctrl_q[CB_DIV+1:CB_DIV]),
    .stb_o (stb)
  );

  assign expire = stb && ((count_q == '0) || (count_q == DATA_W'(1)));

  always_comb begin
    limit_d = limit_q;
    count_d = count_q;
    ctrl_d  = ctrl_q;
    raw_d   = raw_q;
    // counting step
    if (stb) begin
      if (expire) begin
        raw_d = 1'b1;
        if (ctrl_q[CB_ONE]) begin
          count_d        = '0;
          ctrl_d[CB_RUN] = 1'b0;
        end else begin
          count_d = reload_of(ctrl_q, limit_q);
        end
      end else begin
        count_d = count_q - DATA_W'(1);
      end
    end
    // register writes take priority over the step
    if (wr_hit) begin
      unique case (idx_i)
        RI_LIMIT: begin
          limit_d = wdata_i;
          count_d = reload_of(ctrl_q, wdata_i);
        end
        RI_CTRL: begin
          ctrl_d = wdata_i[CTRL_W-1:0];
          if (wdata_i[CB_RUN]) begin
            count_d = reload_of(wdata_i[CTRL_W-1:0], limit_q);
          end
        end
        RI_ICLR:  raw_d   = expire;
        RI_BGLIM: limit_d = wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_q <= '0;
      count_q <= '0;
      ctrl_q  <= CTRL_RST;
      raw_q   <= 1'b0;
    end else begin
      limit_q <= limit_d;
      count_q <= count_d;
      ctrl_q  <= ctrl_d;
      raw_q   <= raw_d;
    end
  end

  always_comb begin
    unique case (idx_i)
      RI_LIMIT, RI_BGLIM: rdata_o = limit_q;
      RI_COUNT:           rdata_o = count_q;
      RI_CTRL:            rdata_o = DATA_W'(ctrl_q);
      RI_RAW:             rdata_o = DATA_W'(raw_q);
      RI_MASKED:          rdata_o = DATA_W'(raw_q && ctrl_q[CB_IE]);
      default:            rdata_o = '0;
    endcase
  end

  assign raw_o = raw_q;
  assign irq_o = raw_q && ctrl_q[CB_IE];
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dtm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_TIMERS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic                rst_n_int;
  logic [N_TIMERS-1:0] t_sel;
  logic [N_TIMERS-1:0] t_raw;
  logic [N_TIMERS-1:0] t_irq;
  logic [DATA_W-1:0]   t_rdata [N_TIMERS];
  reg_idx_e            idx;
  logic                unused_addr_lsb;

  assign unused_addr_lsb = ^addr_i[1:0];

  dtm_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_int)
  );

  dtm_decode #(
    .ADDR_W  (ADDR_W),
    .N_TIMERS(N_TIMERS)
  ) u_dec (
    .sel_i      (sel_i),
    .word_addr_i(addr_i[ADDR_W-1:2]),
    .hit_o      (t_sel),
    .idx_o      (idx)
  );

  for (genvar gi = 0; gi < N_TIMERS; gi++) begin : g_tmr
    dtm_timer #(
      .DATA_W  (DATA_W),
      .NARROW_W(16),
      .PRE_W   (8)
    ) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_n_int),
      .tick_i (tick_i),
      .sel_i  (t_sel[gi]),
      .wr_i   (wr_i),
      .idx_i  (idx),
      .wdata_i(wdata_i),
      .rdata_o(t_rdata[gi]),
      .raw_o  (t_raw[gi]),
      .irq_o  (t_irq[gi])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_TIMERS; i++) begin
      if (t_sel[i]) begin
        rdata_o = rdata_o | t_rdata[i];
      end
    end
  end

  assign irq_o = |t_irq;
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker
  import dtm_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_TIMERS = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic                sel_i,
  input logic                wr_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic                irq_o,
  input logic [N_TIMERS-1:0] t_sel,
  input logic [N_TIMERS-1:0] t_raw
);
  localparam logic [ADDR_W-1:0] TOP_OFS = ADDR_W'(N_TIMERS * BANK_BYTES);

  AST_ONE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(t_sel)); // R1

  AST_HIGH_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && (addr_i >= TOP_OFS)) |-> (rdata_o == '0)); // R3

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|t_raw)); // R5

  for (genvar gi = 0; gi < N_TIMERS; gi++) begin : g_clr
    localparam logic [ADDR_W-1:0] CLR_OFS = ADDR_W'(gi * BANK_BYTES + 12);
    AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i && wr_i && !tick_i && (addr_i[ADDR_W-1:2] == CLR_OFS[ADDR_W-1:2]))
      |=> !t_raw[gi]); // R12
  end
endmodule

bind dual_timer dtm_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .N_TIMERS(N_TIMERS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .sel_i  (sel_i),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .t_sel  (t_sel),
  .t_raw  (t_raw)
);

// File: tb/test_dual_timer.sv
`timescale 1ns/1ps
module test_dual_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        sel_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  dual_timer i_dual_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .sel_i  (sel_i),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    sel_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = 1'b0; addr_i = a;
    #1 v = rdata_o;
    sel_i = 1'b0;
    chk(tag, v, exp);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(negedge clk_i); tick_i = 1'b0;
    end
  endtask

  task automatic t_reset;
    rd_chk("R6 ctrl0", 12'h008, 32'h40);
    rd_chk("R6 ctrl1", 12'h028, 32'h40);
    rd_chk("R6 limit0", 12'h000, 32'h0);
    rd_chk("R6 count1", 12'h024, 32'h0);
    rd_chk("R6 raw0", 12'h010, 32'h0);
    chk("R6 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_decode;
    wr(12'h000, 32'h1234);
    wr(12'h020, 32'hABCD);
    rd_chk("R1 limit0", 12'h000, 32'h1234);
    rd_chk("R2 limit1", 12'h020, 32'hABCD);
    rd_chk("R4 unaligned read", 12'h003, 32'h1234);
    wr(12'h022, 32'h55);
    rd_chk("R4 unaligned write", 12'h021, 32'h55);
    rd_chk("R1 t0 untouched", 12'h000, 32'h1234);
  endtask

  task automatic t_high;
    wr(12'h040, 32'h999);
    wr(12'h058, 32'h777);
    wr(12'hFE0, 32'h1);
    rd_chk("R3 t0 kept", 12'h000, 32'h1234);
    rd_chk("R3 t1 kept", 12'h020, 32'h55);
    rd_chk("R3 read 0x40", 12'h040, 32'h0);
    rd_chk("R3 read 0x58", 12'h058, 32'h0);
    rd_chk("R3 read 0xFE0", 12'hFE0, 32'h0);
  endtask

  task automatic t_periodic;
    wr(12'h000, 32'd3);
    wr(12'h008, 32'h4B);
    rd_chk("R7 loaded", 12'h004, 32'd3);
    ticks(2);
    rd_chk("R7 count after 2", 12'h004, 32'd1);
    chk("R7 no irq yet", {31'b0, irq_o}, 32'h0);
    ticks(1);
    chk("R7 irq on expiry", {31'b0, irq_o}, 32'h1);
    rd_chk("R7 reloaded", 12'h004, 32'd3);
    rd_chk("R7 raw", 12'h010, 32'h1);
    wr(12'h00C, 32'h0);
    chk("R12 cleared", {31'b0, irq_o}, 32'h0);
    ticks(3);
    chk("R7 second period", {31'b0, irq_o}, 32'h1);
    wr(12'h008, 32'h40);
    wr(12'h00C, 32'h0);
  endtask

  task automatic t_oneshot;
    wr(12'h020, 32'd2);
    wr(12'h028, 32'h4D);
    ticks(2);
    rd_chk("R8 count zero", 12'h024, 32'h0);
    rd_chk("R8 run cleared", 12'h028, 32'h4C);
    chk("R8 irq", {31'b0, irq_o}, 32'h1);
    ticks(2);
    rd_chk("R8 stays zero", 12'h024, 32'h0);
    wr(12'h02C, 32'h0);
    chk("R8 cleared", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_free;
    wr(12'h008, 32'h41);
    rd_chk("R9 free16 reload", 12'h004, 32'hFFFF);
    ticks(1);
    rd_chk("R9 free16 step", 12'h004, 32'hFFFE);
    wr(12'h008, 32'h49);
    rd_chk("R9 free32 reload", 12'h004, 32'hFFFF_FFFF);
    ticks(1);
    rd_chk("R9 free32 step", 12'h004, 32'hFFFF_FFFE);
    wr(12'h008, 32'h40);
    wr(12'h000, 32'h1_0005);
    wr(12'h008, 32'h43);
    rd_chk("R9 periodic16 truncated", 12'h004, 32'd5);
    ticks(1);
    rd_chk("R9 periodic16 step", 12'h004, 32'd4);
    rd_chk("R9 limit kept whole", 12'h000, 32'h1_0005);
    wr(12'h008, 32'h40);
  endtask

  task automatic t_prescale;
    wr(12'h000, 32'd2);
    wr(12'h008, 32'h5B);
    ticks(15);
    rd_chk("R10 div16 hold", 12'h004, 32'd2);
    ticks(1);
    rd_chk("R10 div16 step", 12'h004, 32'd1);
    ticks(16);
    rd_chk("R10 div16 expiry", 12'h010, 32'h1);
    rd_chk("R10 div16 reload", 12'h004, 32'd2);
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'h6B);
    ticks(255);
    rd_chk("R10 div256 hold", 12'h004, 32'd2);
    ticks(1);
    rd_chk("R10 div256 step", 12'h004, 32'd1);
    wr(12'h008, 32'h40);
    wr(12'h00C, 32'h0);
  endtask

  task automatic t_bgload;
    wr(12'h028, 32'h4A);
    wr(12'h020, 32'd10);
    wr(12'h038, 32'd50);
    rd_chk("R11 bg limit", 12'h020, 32'd50);
    rd_chk("R11 count kept", 12'h024, 32'd10);
    wr(12'h024, 32'd77);
    rd_chk("R11 count write ignored", 12'h024, 32'd10);
    wr(12'h028, 32'h4B);
    rd_chk("R11 run reloads", 12'h024, 32'd50);
    wr(12'h028, 32'h4A);
  endtask

  task automatic t_irq_mix;
    wr(12'h008, 32'h0A);
    wr(12'h000, 32'd1);
    wr(12'h028, 32'h4A);
    wr(12'h020, 32'd2);
    wr(12'h008, 32'h0B);
    wr(12'h028, 32'h4B);
    ticks(1);
    rd_chk("R12 raw0 set", 12'h010, 32'h1);
    rd_chk("R12 masked0 zero", 12'h014, 32'h0);
    chk("R12 masked no irq", {31'b0, irq_o}, 32'h0);
    ticks(1);
    chk("R5 irq from t1", {31'b0, irq_o}, 32'h1);
    rd_chk("R5 masked1", 12'h034, 32'h1);
    wr(12'h00C, 32'h0);
    chk("R5 irq kept by t1", {31'b0, irq_o}, 32'h1);
    rd_chk("R5 raw1 kept", 12'h030, 32'h1);
    wr(12'h02C, 32'h0);
    chk("R5 irq low", {31'b0, irq_o}, 32'h0);
    wr(12'h028, 32'h4A);
    wr(12'h008, 32'h4B);
    ticks(1);
    chk("R5 irq from t0", {31'b0, irq_o}, 32'h1);
    wr(12'h008, 32'h0B);
    chk("R12 enable off drops irq", {31'b0, irq_o}, 32'h0);
    rd_chk("R12 raw0 still set", 12'h010, 32'h1);
    wr(12'h008, 32'h40);
    wr(12'h00C, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_decode();
    t_high();
    t_periodic();
    t_oneshot();
    t_free();
    t_prescale();
    t_bgload();
    t_irq_mix();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule